// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a variable-length instruction decoder. It takes the instruction stream one byte per cycle under a valid/ready handshake, together with a flag that selects 64-bit operating mode. It accepts prefix bytes until it meets the first byte that is not a prefix. It then reports which prefixes were decoded, the four extension bits of the last REX byte, the byte offset of the first opcode byte and a mask that marks superfluous prefix bytes by position.

Each prefix group has its own register holding the offset where that group last appeared. When a group repeats, the earlier copy is marked at once. Once the downstream decoder knows which prefixes the instruction actually used, it sends a "used" vector. Each group whose decoded and used bits differ then marks its last recorded position. A run of prefixes that fills the 15-byte instruction limit ends the scan with a length error.

Top module: `pfx_scanner`

## Requirements
- R1: After reset, and after a `next_inst` pulse while `done` is high, the block shows `in_ready`=1, `done`=0, `len_err`=0, `pfx_flags`=0, `rex_ext`=0 and `unused_mask`=0, and every group's position is "none" (15).
- R2: Prefix bytes set these `pfx_flags` bits: F0→0, F2→1, F3→2, 2E→3, 36→4, 3E→5, 26→6, 64→7, 65→8, 66→9, 67→10, REX→11. The groups are lock/repeat (bits 0-2), segment (bits 3-8), operand size (9), address size (10) and REX (11). Flags accumulate by OR within one instruction.
- R3: Bytes 40-4F are REX prefixes only when `mode64`=1. When `mode64`=0 they end the scan as an opcode byte.
- R4: `rex_ext` holds bits 3:0 of the most recent REX byte of the instruction.
- R5: The first non-prefix byte is consumed. From the next cycle, `done`=1, `in_ready`=0, and `op_off` equals that byte's offset from the instruction start (0-based).
- R6: A prefix whose group has already appeared in the instruction sets `unused_mask` bit p, where p is the earlier offset. The new offset becomes the group's position. Bit i of `unused_mask` is byte offset i.
- R7: If 15 consecutive prefix bytes are accepted, the scan ends after the 15th with `done`=1, `len_err`=1 and `op_off`=15. The repeat rule of R6 still applies to those bytes.
- R8: A `fin_valid` pulse while `done`=1 XORs `fin_used` with `pfx_flags`. For each group with a differing bit, it sets the mask bit at that group's last position. A group never seen sets nothing. The mask only gains bits.
- R9: `fin_valid` is ignored while scanning, and `in_valid` is ignored while `done`=1.
- R10: While `done`=1 and neither `fin_valid` nor `next_inst` is asserted, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 selects 64-bit mode (REX recognised) |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Scanner accepts a byte this cycle |
| fin_valid | input | 1 | Apply the used-prefix vector |
| fin_used | input | 12 | Prefixes used by the downstream decoder, same bit order as `pfx_flags` |
| next_inst | input | 1 | Release the result and start a new instruction |
| done | output | 1 | Scan finished, results valid |
| len_err | output | 1 | Prefix run reached the 15-byte limit |
| pfx_flags | output | 12 | Decoded prefix flags |
| rex_ext | output | 4 | W, R, X, B bits of the last REX |
| op_off | output | 4 | Offset of first opcode byte (15 on length error) |
| unused_mask | output | 15 | Superfluous prefixes by byte offset |

## Verification
A group position register that holds the wrong offset, or that is not returned to "none", shows up on `unused_mask`. It appears the cycle after the next prefix of that group is accepted, or the cycle after finalisation, as a bit at the wrong offset or as a bit where none belongs. A fault in the byte counter moves `op_off` and the point where `len_err` rises, and both are visible as soon as `done` rises. A fault in classification changes `pfx_flags` and `rex_ext` from the first wrong byte on, and can end the scan a byte early or late.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int NFLAG = 12;
    localparam int NGRP  = 5;
    localparam int GW    = $clog2(NGRP);

    typedef enum logic [GW-1:0] {
        GRP_LOREP = 3'd0,
        GRP_SEG   = 3'd1,
        GRP_OPSZ  = 3'd2,
        GRP_ADSZ  = 3'd3,
        GRP_REX   = 3'd4
    } grp_e;

    typedef struct packed {
        logic             is_pfx;
        grp_e             grp;
        logic [NFLAG-1:0] flag;
    } cls_t;

    // Flag vector bits covered by one group.
    function automatic logic [NFLAG-1:0] grp_mask(input int g);
        case (g)
            0:       return 12'h007;
            1:       return 12'h1F8;
            2:       return 12'h200;
            3:       return 12'h400;
            default: return 12'h800;
        endcase
    endfunction

    function automatic cls_t classify(input logic [7:0] b, input logic m64);
        cls_t c;
        c.is_pfx = 1'b1;
        c.grp    = GRP_LOREP;
        c.flag   = '0;
        case (b)
            8'hF0: c.flag[0] = 1'b1;
            8'hF2: c.flag[1] = 1'b1;
            8'hF3: c.flag[2] = 1'b1;
            8'h2E: begin c.grp = GRP_SEG; c.flag[3] = 1'b1; end
            8'h36: begin c.grp = GRP_SEG; c.flag[4] = 1'b1; end
            8'h3E: begin c.grp = GRP_SEG; c.flag[5] = 1'b1; end
            8'h26: begin c.grp = GRP_SEG; c.flag[6] = 1'b1; end
            8'h64: begin c.grp = GRP_SEG; c.flag[7] = 1'b1; end
            8'h65: begin c.grp = GRP_SEG; c.flag[8] = 1'b1; end
            8'h66: begin c.grp = GRP_OPSZ; c.flag[9] = 1'b1; end
            8'h67: begin c.grp = GRP_ADSZ; c.flag[10] = 1'b1; end
            default: begin
                if (m64 && b[7:4] == 4'h4) begin
                    c.grp      = GRP_REX;
                    c.flag[11] = 1'b1;
                end else begin
                    c.is_pfx = 1'b0;
                end
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       mode64_i,
    output cls_t       cls_o
);
    always_comb cls_o = classify(byte_i, mode64_i);
endmodule

// File: rtl/pfx_group_track.sv
module pfx_group_track
    import pfx_pkg::*;
#(
    parameter int MASKW = 15,
    parameter int POSW  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             hit_i,
    input  grp_e             grp_i,
    input  logic [POSW-1:0]  pos_i,
    input  logic             fin_i,
    input  logic [NGRP-1:0]  grp_diff_i,
    output logic [MASKW-1:0] mark_o
);
    localparam logic [POSW-1:0] NONE = '1;

    logic [POSW-1:0] pos_q [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst || clear_i)
                pos_q[g] <= NONE;
            else if (hit_i && grp_i == grp_e'(g))
                pos_q[g] <= pos_i;
        end
    end

    // Bits to add to the unused mask: displaced copies and finalised groups.
    always_comb begin
        mark_o = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (pos_q[g] != NONE &&
                ((hit_i && grp_i == grp_e'(g)) || (fin_i && grp_diff_i[g])))
                mark_o[pos_q[g]] = 1'b1;
        end
    end
endmodule

// File: rtl/pfx_scanner.sv
module pfx_scanner
    import pfx_pkg::*;
#(
    parameter int MAX_LEN = 15,
    parameter int POSW    = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode64,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic               in_ready,
    input  logic               fin_valid,
    input  logic [NFLAG-1:0]   fin_used,
    input  logic               next_inst,
    output logic               done,
    output logic               len_err,
    output logic [NFLAG-1:0]   pfx_flags,
    output logic [3:0]         rex_ext,
    output logic [POSW-1:0]    op_off,
    output logic [MAX_LEN-1:0] unused_mask
);
    typedef enum logic {ST_SCAN, ST_DONE} st_e;

    localparam logic [POSW-1:0] LAST_SLOT = POSW'(MAX_LEN - 1);
    localparam logic [POSW-1:0] LIMIT_OFF = POSW'(MAX_LEN);

    st_e               st_q;
    logic [POSW-1:0]   idx_q;
    cls_t              cls;
    logic              acc, hit, fin_en, clear;
    logic [NFLAG-1:0]  diff;
    logic [NGRP-1:0]   grp_diff;
    logic [MAX_LEN-1:0] mark;

    pfx_classify u_cls (
        .byte_i  (in_byte),
        .mode64_i(mode64),
        .cls_o   (cls)
    );

    assign acc    = in_valid && st_q == ST_SCAN;
    assign hit    = acc && cls.is_pfx;
    assign fin_en = fin_valid && st_q == ST_DONE;
    assign clear  = next_inst && st_q == ST_DONE;
    assign diff   = pfx_flags ^ fin_used;

    always_comb begin
        for (int g = 0; g < NGRP; g++)
            grp_diff[g] = |(diff & grp_mask(g));
    end

    pfx_group_track #(.MASKW(MAX_LEN), .POSW(POSW)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (clear),
        .hit_i     (hit),
        .grp_i     (cls.grp),
        .pos_i     (idx_q),
        .fin_i     (fin_en),
        .grp_diff_i(grp_diff),
        .mark_o    (mark)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st_q        <= ST_SCAN;
            idx_q       <= '0;
            len_err     <= 1'b0;
            pfx_flags   <= '0;
            rex_ext     <= '0;
            op_off      <= '0;
            unused_mask <= '0;
        end else begin
            unused_mask <= unused_mask | mark;
            if (acc) begin
                if (cls.is_pfx) begin
                    pfx_flags <= pfx_flags | cls.flag;
                    if (cls.grp == GRP_REX) rex_ext <= in_byte[3:0];
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_SLOT) begin
                        st_q    <= ST_DONE;
                        len_err <= 1'b1;
                        op_off  <= LIMIT_OFF;
                    end
                end else begin
                    st_q   <= ST_DONE;
                    op_off <= idx_q;
                end
            end
        end
    end

    assign in_ready = st_q == ST_SCAN;
    assign done     = st_q == ST_DONE;
endmodule

// File: rtl/pfx_scanner_chk.sv
module pfx_scanner_chk (
    input logic        clk,
    input logic        rst,
    input logic        mode64,
    input logic        in_valid,
    input logic [7:0]  in_byte,
    input logic        in_ready,
    input logic        fin_valid,
    input logic        next_inst,
    input logic        done,
    input logic        len_err,
    input logic [11:0] pfx_flags,
    input logic [3:0]  rex_ext,
    input logic [3:0]  op_off,
    input logic [14:0] unused_mask
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!done && !len_err && pfx_flags == '0 && unused_mask == '0 && rex_ext == '0)); // R1

    AST_REX_IS_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !mode64 && in_byte[7:4] == 4'h4) |=> (done && !len_err)); // R3

    AST_MASK_BELOW_OPCODE: assert property (@(posedge clk) disable iff (rst)
        done |-> ((unused_mask >> op_off) == '0)); // R6

    AST_LIMIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
        len_err |-> (done && op_off == 4'd15)); // R7

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !fin_valid && !next_inst) |=>
            (done && $stable(unused_mask) && $stable(pfx_flags) && $stable(op_off) && $stable(rex_ext))); // R10
endmodule

bind pfx_scanner pfx_scanner_chk u_chk (.*);

// File: tb/sim_pfx_scanner.sv
`timescale 1ns/1ps
module sim_pfx_scanner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode64 = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        fin_valid = 1'b0;
    logic [11:0] fin_used = '0;
    logic        next_inst = 1'b0;
    logic        in_ready, done, len_err;
    logic [11:0] pfx_flags;
    logic [3:0]  rex_ext, op_off;
    logic [14:0] unused_mask;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pfx_scanner u0 (.*);

    typedef struct packed {
        logic          m64;
        logic [119:0]  bytes;   // byte i at bits [8i+7:8i]
        logic [4:0]    nbytes;
        logic [11:0]   used;
        logic [11:0]   e_flags;
        logic [3:0]    e_rex;
        logic [3:0]    e_off;
        logic          e_lerr;
        logic [14:0]   e_mask;
        logic [14:0]   e_final;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{1'b1, {112'h0, 8'h90}, 5'd1, 12'h000, 12'h000, 4'h0, 4'd0, 1'b0, 15'h0000, 15'h0000},
        '{1'b1, {80'h0, 8'h0F, 8'h48, 8'h66, 8'hF3, 8'h66}, 5'd5, 12'hA00, 12'hA04, 4'h8, 4'd4, 1'b0, 15'h0001, 15'h0003},
        '{1'b0, {96'h0, 8'h41, 8'h3E, 8'h2E}, 5'd3, 12'h020, 12'h028, 4'h0, 4'd2, 1'b0, 15'h0001, 15'h0003},
        '{1'b1, {80'h0, 8'hC3, 8'hF0, 8'h67, 8'h4F, 8'h40}, 5'd5, 12'hC01, 12'hC01, 4'hF, 4'd4, 1'b0, 15'h0001, 15'h0001},
        '{1'b1, {15{8'h66}}, 5'd15, 12'h000, 12'h200, 4'h0, 4'd15, 1'b1, 15'h3FFF, 15'h7FFF},
        '{1'b0, {64'h0, 8'h8B, 8'hF2, 8'hF2, 8'h36, 8'h26, 8'h65, 8'h64}, 5'd7, 12'h212, 12'h1D2, 4'h0, 4'd6, 1'b0, 15'h0017, 15'h001F},
        '{1'b0, {8'h90, {14{8'hF3}}}, 5'd15, 12'h004, 12'h004, 4'h0, 4'd14, 1'b0, 15'h1FFF, 15'h1FFF}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_fin(input logic [11:0] u);
        fin_valid = 1'b1;
        fin_used  = u;
        @(negedge clk);
        fin_valid = 1'b0;
    endtask

    task automatic pulse_next();
        next_inst = 1'b1;
        @(negedge clk);
        next_inst = 1'b0;
    endtask

    task automatic chk_clean(input string req);
        chk(in_ready && !done && !len_err, req, {done, len_err, in_ready}, 3'b001);
        chk(pfx_flags == 0 && rex_ext == 0 && unused_mask == 0, req,
            {pfx_flags, rex_ext, unused_mask}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_clean("R1 reset");

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            mode64 = VT[v].m64;
            for (int i = 0; i < int'(VT[v].nbytes); i++)
                send(VT[v].bytes[8*i +: 8]);
            chk(done && !in_ready, "R5 done", {done, in_ready}, 2'b10);
            chk(pfx_flags == VT[v].e_flags, "R2 flags", pfx_flags, VT[v].e_flags);
            chk(rex_ext == VT[v].e_rex, "R4 rex", rex_ext, VT[v].e_rex);
            chk(op_off == VT[v].e_off, "R5 offset", op_off, VT[v].e_off);
            chk(len_err == VT[v].e_lerr, "R7 len_err", len_err, VT[v].e_lerr);
            chk(unused_mask == VT[v].e_mask, "R6 mask", unused_mask, VT[v].e_mask);
            @(negedge clk);
            chk(unused_mask == VT[v].e_mask && done, "R10 hold", unused_mask, VT[v].e_mask);
            pulse_fin(VT[v].used);
            chk(unused_mask == VT[v].e_final, "R8 final", unused_mask, VT[v].e_final);
            pulse_next();
            chk_clean("R1 next_inst");
        end

        // R9: fin_valid during scan has no effect
        mode64 = 1'b1;
        send(8'h66);
        send(8'hF3);
        pulse_fin(12'h000);
        chk(in_ready && unused_mask == 0, "R9 fin ignored in scan", unused_mask, 0);
        send(8'h90);
        chk(unused_mask == 0 && op_off == 4'd2, "R9 fin ignored mask", {op_off, unused_mask}, {4'd2, 15'h0});

        // R9: bytes offered while done are not taken
        send(8'h66);
        chk(pfx_flags == 12'h204 && op_off == 4'd2 && unused_mask == 0, "R9 byte ignored in done",
            {pfx_flags, op_off}, {12'h204, 4'd2});
        pulse_next();
        send(8'h90);
        chk(op_off == 4'd0 && pfx_flags == 0, "R9 next instruction starts fresh", {pfx_flags, op_off}, 0);
        pulse_next();

        // R3: REX byte in 32-bit mode ends the scan at once
        mode64 = 1'b0;
        send(8'h66);
        send(8'h48);
        chk(done && op_off == 4'd1 && pfx_flags == 12'h200 && rex_ext == 0, "R3 rex as opcode",
            {pfx_flags, rex_ext, op_off}, {12'h200, 4'h0, 4'd1});
        pulse_next();

        // R1: reset in the middle of a scan
        send(8'hF0);
        send(8'hF0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_clean("R1 mid-scan reset");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule